// File: doc/BRIEF.md
# Hardware Pointer Overlay

This block lays a 32x32 pointer over the pixel stream that display refresh produces. For every valid pixel the block compares the beam X/Y coordinates with the pointer position. When the pixel falls inside the pointer window, the block fetches one bit from an AND mask and one bit from an XOR mask held in a local pattern RAM. It then returns black, white, the screen pixel or its inverse. Outside the window, or while the pointer is switched off, the screen pixel passes through unchanged. The result appears two clocks after the pixel enters.

A host programs the pointer through a small byte-wide register port: split high/low X and Y position, an enable bit, and a pattern base that names a 256-byte block of the pattern RAM. A separate byte-wide write port fills the pattern RAM. Each 256-byte block holds a 128-byte AND map followed by a 128-byte XOR map. Within each map the rows are 4 bytes apart and the leftmost pixel of each byte sits in bit 7.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, out_valid and pix_out are 0, the pointer is disabled and both position registers read as 0, so the first pixels pass through unchanged.
- R2: While the enable bit (register 5, bit 0) is clear, pix_out equals the pix_in of the same pixel for every beam position.
- R3: A pixel is inside the window when cx <= beam_x <= cx+31 and cy <= beam_y <= cy+31, both bounds inclusive. Every pixel outside the window passes through unchanged.
- R4: Inside the window, the pair (AND bit, XOR bit) selects the output: 00 gives all zeros, 01 gives the bitwise NOT of pix_in, 10 gives pix_in and 11 gives all ones.
- R5: For window offset (col, row), the AND bit is bit 7-(col mod 8) of block byte row*4 + col/8, and the XOR bit is the same bit of block byte 128 + row*4 + col/8.
- R6: The pattern block starts at pattern RAM byte address base*256. Only the low BLK_W bits of the base register (register 4) are used, so bases that differ only above those bits select the same block.
- R7: X is 11 bits wide: bits 10:8 come from bits 2:0 of register 0 and bits 7:0 from register 1. Y is 10 bits wide: bits 9:8 come from bits 1:0 of register 2 and bits 7:0 from register 3. Higher bits written to registers 0 and 2 are ignored.
- R8: A pixel presented with pix_valid in one cycle appears on pix_out with out_valid exactly two clock edges later. out_valid is low when no pixel was presented.
- R9: A pattern byte written in the same cycle that a pixel fetches it gives the pixel the old byte. A register write in the same cycle as a pixel acts only on later pixels.
- R10: The window does not wrap past the top of the coordinate range: with cx near 2047, small beam_x values stay outside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 X high, 1 X low, 2 Y high, 3 Y low, 4 base, 5 control |
| reg_wdata | input | 8 | Register write data |
| pat_we | input | 1 | Pattern RAM write strobe |
| pat_addr | input | BLK_W+8 | Pattern RAM byte address |
| pat_wdata | input | 8 | Pattern RAM write data |
| pix_valid | input | 1 | Pixel present this cycle |
| beam_x | input | XW | Beam column of the pixel |
| beam_y | input | YW | Beam line of the pixel |
| pix_in | input | PW | Screen pixel from refresh |
| out_valid | output | 1 | Output pixel present |
| pix_out | output | PW | Pixel with the pointer applied |

## Verification
Two pairs of functions can fall in the same cycle. A pattern write can land on the same byte that a pixel is fetching, and a position register write can coincide with a pixel that the old position places inside the window. The bench drives each pair on the same clock edge. It expects the pixel to reflect the old pattern byte or the old position, and it expects the next pixel to reflect the new one. It also checks the window bounds one pixel inside and one pixel outside on each side, and at the top of the coordinate range.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

    // Host register indices
    typedef enum logic [2:0] {
        RA_XHI  = 3'd0,
        RA_XLO  = 3'd1,
        RA_YHI  = 3'd2,
        RA_YLO  = 3'd3,
        RA_BASE = 3'd4,
        RA_CTRL = 3'd5
    } reg_addr_e;

    // Mask pair decode
    typedef enum logic [1:0] {
        MIX_BLACK  = 2'b00,
        MIX_INVERT = 2'b01,
        MIX_SCREEN = 2'b10,
        MIX_WHITE  = 2'b11
    } mix_e;

    localparam int CTRL_EN_BIT = 0;

endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int XW = 11,
    parameter int YW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [XW-1:0] cur_x,
    output logic [YW-1:0] cur_y,
    output logic [7:0]    cur_base,
    output logic          cur_en
);

    localparam int XHW = XW - 8;
    localparam int YHW = YW - 8;

    typedef struct packed {
        logic [XW-1:0] x;
        logic [YW-1:0] y;
        logic [7:0]    base;
        logic          en;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            case (reg_addr)
                RA_XHI:  r_d.x[XW-1:8] = reg_wdata[XHW-1:0];
                RA_XLO:  r_d.x[7:0]    = reg_wdata;
                RA_YHI:  r_d.y[YW-1:8] = reg_wdata[YHW-1:0];
                RA_YLO:  r_d.y[7:0]    = reg_wdata;
                RA_BASE: r_d.base      = reg_wdata;
                RA_CTRL: r_d.en        = reg_wdata[CTRL_EN_BIT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign cur_x    = r_q.x;
    assign cur_y    = r_q.y;
    assign cur_base = r_q.base;
    assign cur_en   = r_q.en;

    AST_XHI_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == RA_XHI) |=> $stable(cur_x[XW-1:8])); // R7
    AST_YHI_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == RA_YHI) |=> $stable(cur_y[YW-1:8])); // R7

endmodule

// File: rtl/cursor_hit.sv
module cursor_hit #(
    parameter int XW      = 11,
    parameter int YW      = 10,
    parameter int PW      = 8,
    parameter int CUR_LOG = 5,
    parameter int BLK_W   = 2,
    localparam int PLANE_AW = 2 * CUR_LOG - 3,
    localparam int RAM_AW   = BLK_W + PLANE_AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_valid,
    input  logic [XW-1:0]     beam_x,
    input  logic [YW-1:0]     beam_y,
    input  logic [PW-1:0]     pix_in,
    input  logic [XW-1:0]     cur_x,
    input  logic [YW-1:0]     cur_y,
    input  logic [7:0]        cur_base,
    input  logic              cur_en,
    output logic [RAM_AW-1:0] and_addr,
    output logic [RAM_AW-1:0] xor_addr,
    output logic              s_valid,
    output logic              s_hit,
    output logic [2:0]        s_bit,
    output logic [PW-1:0]     s_pix
);

    localparam int CUR_SZ = 1 << CUR_LOG;
    localparam logic [XW-1:0] XLIM = XW'(CUR_SZ);
    localparam logic [YW-1:0] YLIM = YW'(CUR_SZ);

    typedef struct packed {
        logic          valid;
        logic          hit;
        logic [2:0]    bsel;
        logic [PW-1:0] pix;
    } stage_t;

    stage_t st_d, st_q;

    logic [XW-1:0]       dx;
    logic [YW-1:0]       dy;
    logic                in_x, in_y;
    logic [PLANE_AW-1:0] plane_off;

    always_comb begin
        dx   = beam_x - cur_x;
        dy   = beam_y - cur_y;
        in_x = (beam_x >= cur_x) && (dx < XLIM);
        in_y = (beam_y >= cur_y) && (dy < YLIM);
        plane_off = {dy[CUR_LOG-1:0], dx[CUR_LOG-1:3]};
        and_addr  = {cur_base[BLK_W-1:0], 1'b0, plane_off};
        xor_addr  = {cur_base[BLK_W-1:0], 1'b1, plane_off};

        st_d.valid = pix_valid;
        st_d.hit   = pix_valid && cur_en && in_x && in_y;
        st_d.bsel  = ~dx[2:0];
        st_d.pix   = pix_in;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign s_valid = st_q.valid;
    assign s_hit   = st_q.hit;
    assign s_bit   = st_q.bsel;
    assign s_pix   = st_q.pix;

    AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        s_hit |-> $past(cur_en)); // R2

endmodule

// File: rtl/cursor_pattern_ram.sv
module cursor_pattern_ram #(
    parameter int RAM_AW = 10,
    localparam int DEPTH = 1 << RAM_AW
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [RAM_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [RAM_AW-1:0] and_addr,
    input  logic [RAM_AW-1:0] xor_addr,
    output logic [7:0]        and_byte,
    output logic [7:0]        xor_byte
);

    logic [7:0] mem [DEPTH];
    logic [7:0] and_q, xor_q;

    // Reads sample the array before this edge's write lands.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        and_q <= mem[and_addr];
        xor_q <= mem[xor_addr];
    end

    assign and_byte = and_q;
    assign xor_byte = xor_q;

endmodule

// File: rtl/cursor_mixer.sv
module cursor_mixer
    import cursor_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          s_valid,
    input  logic          s_hit,
    input  logic [2:0]    s_bit,
    input  logic [PW-1:0] s_pix,
    input  logic [7:0]    and_byte,
    input  logic [7:0]    xor_byte,
    output logic          out_valid,
    output logic [PW-1:0] pix_out
);

    typedef struct packed {
        logic          valid;
        logic [PW-1:0] pix;
    } out_t;

    out_t o_d, o_q;
    logic and_bit, xor_bit;
    mix_e sel;

    always_comb begin
        and_bit = and_byte[s_bit];
        xor_bit = xor_byte[s_bit];
        sel     = mix_e'({and_bit, xor_bit});
        o_d.valid = s_valid;
        o_d.pix   = s_pix;
        if (s_hit) begin
            case (sel)
                MIX_BLACK:  o_d.pix = '0;
                MIX_INVERT: o_d.pix = ~s_pix;
                MIX_SCREEN: o_d.pix = s_pix;
                MIX_WHITE:  o_d.pix = '1;
                default:    o_d.pix = s_pix;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) o_q <= '0;
        else     o_q <= o_d;
    end

    assign out_valid = o_q.valid;
    assign pix_out   = o_q.pix;

    AST_PASS_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        (s_valid && !s_hit) |=> (pix_out == $past(s_pix))); // R3
    AST_WHITE_PAIR: assert property (@(posedge clk) disable iff (rst)
        (s_hit && and_bit && xor_bit) |=> (pix_out == '1)); // R4
    AST_BLACK_PAIR: assert property (@(posedge clk) disable iff (rst)
        (s_hit && !and_bit && !xor_bit) |=> (pix_out == '0)); // R4
    AST_INVERT_PAIR: assert property (@(posedge clk) disable iff (rst)
        (s_hit && !and_bit && xor_bit) |=> (pix_out == ~$past(s_pix))); // R4
    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        s_valid |=> out_valid); // R8

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
    parameter int XW      = 11,
    parameter int YW      = 10,
    parameter int PW      = 8,
    parameter int CUR_LOG = 5,
    parameter int BLK_W   = 2,
    localparam int RAM_AW = BLK_W + 2 * CUR_LOG - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              pat_we,
    input  logic [RAM_AW-1:0] pat_addr,
    input  logic [7:0]        pat_wdata,
    input  logic              pix_valid,
    input  logic [XW-1:0]     beam_x,
    input  logic [YW-1:0]     beam_y,
    input  logic [PW-1:0]     pix_in,
    output logic              out_valid,
    output logic [PW-1:0]     pix_out
);

    logic [XW-1:0]     cur_x;
    logic [YW-1:0]     cur_y;
    logic [7:0]        cur_base;
    logic              cur_en;
    logic [RAM_AW-1:0] and_addr, xor_addr;
    logic              s_valid, s_hit;
    logic [2:0]        s_bit;
    logic [PW-1:0]     s_pix;
    logic [7:0]        and_byte, xor_byte;

    cursor_regs #(.XW(XW), .YW(YW)) u_regs (
        .clk, .rst, .reg_we, .reg_addr, .reg_wdata,
        .cur_x, .cur_y, .cur_base, .cur_en
    );

    cursor_hit #(.XW(XW), .YW(YW), .PW(PW), .CUR_LOG(CUR_LOG), .BLK_W(BLK_W)) u_hit (
        .clk, .rst, .pix_valid, .beam_x, .beam_y, .pix_in,
        .cur_x, .cur_y, .cur_base, .cur_en,
        .and_addr, .xor_addr, .s_valid, .s_hit, .s_bit, .s_pix
    );

    cursor_pattern_ram #(.RAM_AW(RAM_AW)) u_ram (
        .clk, .wr_en(pat_we), .wr_addr(pat_addr), .wr_data(pat_wdata),
        .and_addr, .xor_addr, .and_byte, .xor_byte
    );

    cursor_mixer #(.PW(PW)) u_mix (
        .clk, .rst, .s_valid, .s_hit, .s_bit, .s_pix,
        .and_byte, .xor_byte, .out_valid, .pix_out
    );

    AST_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
        !s_valid |=> !out_valid); // R8

endmodule

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        pat_we = 1'b0;
    logic [9:0]  pat_addr = '0;
    logic [7:0]  pat_wdata = '0;
    logic        pix_valid = 1'b0;
    logic [10:0] beam_x = '0;
    logic [9:0]  beam_y = '0;
    logic [7:0]  pix_in = '0;
    logic        out_valid;
    logic [7:0]  pix_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    cursor_overlay u_cursor_overlay (
        .clk, .rst, .reg_we, .reg_addr, .reg_wdata,
        .pat_we, .pat_addr, .pat_wdata,
        .pix_valid, .beam_x, .beam_y, .pix_in,
        .out_valid, .pix_out
    );

    typedef struct packed {
        logic [10:0] cx;
        logic [9:0]  cy;
        logic [10:0] bx;
        logic [9:0]  by;
        logic [7:0]  pin;
        logic [7:0]  exp;
    } vec_t;

    // Block 0 pattern: AND 0xCC / XOR 0xAA everywhere, except row 5 byte 2
    // (AND 0x0F / XOR 0x33). Column mod 4: 0 white, 1 screen, 2 invert, 3 black.
    localparam logic [57:0] VECS [18] = '{
        {11'd100, 10'd50, 11'd100, 10'd50, 8'h5A, 8'hFF},
        {11'd100, 10'd50, 11'd101, 10'd50, 8'h5A, 8'h5A},
        {11'd100, 10'd50, 11'd102, 10'd50, 8'h5A, 8'hA5},
        {11'd100, 10'd50, 11'd103, 10'd50, 8'h5A, 8'h00},
        {11'd100, 10'd50, 11'd99,  10'd50, 8'h5A, 8'h5A},
        {11'd100, 10'd50, 11'd131, 10'd50, 8'h5A, 8'h00},
        {11'd100, 10'd50, 11'd132, 10'd50, 8'h5A, 8'h5A},
        {11'd100, 10'd50, 11'd100, 10'd81, 8'h5A, 8'hFF},
        {11'd100, 10'd50, 11'd100, 10'd82, 8'h5A, 8'h5A},
        {11'd100, 10'd50, 11'd100, 10'd49, 8'h5A, 8'h5A},
        {11'd100, 10'd50, 11'd116, 10'd55, 8'h3C, 8'h00},
        {11'd100, 10'd50, 11'd118, 10'd55, 8'h3C, 8'hC3},
        {11'd100, 10'd50, 11'd120, 10'd55, 8'h3C, 8'h3C},
        {11'd100, 10'd50, 11'd122, 10'd55, 8'h3C, 8'hFF},
        {11'd100, 10'd50, 11'd116, 10'd54, 8'h3C, 8'hFF},
        {11'd2040, 10'd1000, 11'd2047, 10'd1023, 8'h77, 8'h00},
        {11'd2040, 10'd1000, 11'd2,    10'd1000, 8'h77, 8'h77},
        {11'd2040, 10'd1000, 11'd2042, 10'd1000, 8'h77, 8'h88}
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wr_pat(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        pat_we = 1'b1; pat_addr = a; pat_wdata = d;
        @(negedge clk);
        pat_we = 1'b0;
    endtask

    task automatic set_pos(input logic [10:0] cx, input logic [9:0] cy);
        wr_reg(3'd0, {5'b0, cx[10:8]});
        wr_reg(3'd1, cx[7:0]);
        wr_reg(3'd2, {6'b0, cy[9:8]});
        wr_reg(3'd3, cy[7:0]);
    endtask

    // Drive at a negedge, sample two edges later at a negedge.
    task automatic run_pix(input logic [10:0] bx, input logic [9:0] by,
                           input logic [7:0] pin, output logic [7:0] got);
        @(negedge clk);
        pix_valid = 1'b1; beam_x = bx; beam_y = by; pix_in = pin;
        @(negedge clk);
        pix_valid = 1'b0;
        @(negedge clk);
        got = pix_out;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] got;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid in reset", {7'b0, out_valid}, 8'h00);
        chk("R1 pix_out in reset", pix_out, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        // Load pattern block 0 and block 1 (block 1 all zero: black)
        for (int a = 0; a < 256; a++) begin
            logic [9:0] ad;
            logic [7:0] d;
            ad = 10'(a);
            if (ad[7] == 1'b0) d = (ad[6:2] == 5'd5 && ad[1:0] == 2'd2) ? 8'h0F : 8'hCC;
            else               d = (ad[6:2] == 5'd5 && ad[1:0] == 2'd2) ? 8'h33 : 8'hAA;
            wr_pat(ad, d);
            wr_pat(ad + 10'd256, 8'h00);
        end

        // R1/R2: defaults give cx=cy=0 but disabled: pass
        run_pix(11'd0, 10'd0, 8'h96, got);
        chk("R1 R2 default pass-through", got, 8'h96);

        // R8: latency
        @(negedge clk);
        pix_valid = 1'b1; beam_x = 11'd5; beam_y = 10'd5; pix_in = 8'h11;
        @(negedge clk);
        pix_valid = 1'b0;
        chk("R8 valid after one edge", {7'b0, out_valid}, 8'h00);
        @(negedge clk);
        chk("R8 valid after two edges", {7'b0, out_valid}, 8'h01);
        chk("R8 pixel after two edges", pix_out, 8'h11);
        @(negedge clk);
        chk("R8 valid drops", {7'b0, out_valid}, 8'h00);

        // Vector table: R3 R4 R5 R7 R10
        wr_reg(3'd4, 8'h00);
        wr_reg(3'd5, 8'h01);
        for (int i = 0; i < 18; i++) begin
            vec_t v;
            v = vec_t'(VECS[i]);
            set_pos(v.cx, v.cy);
            run_pix(v.bx, v.by, v.pin, got);
            chk($sformatf("R3 R4 R5 R7 R10 vector %0d", i), got, v.exp);
        end

        // R7: upper bits of high registers ignored
        set_pos(11'd100, 10'd50);
        wr_reg(3'd0, 8'hF8);
        wr_reg(3'd2, 8'hFC);
        run_pix(11'd100, 10'd50, 8'h5A, got);
        chk("R7 high-reg upper bits ignored", got, 8'hFF);

        // R6: base selects the block; upper base bits ignored
        wr_reg(3'd4, 8'h01);
        run_pix(11'd100, 10'd50, 8'h5A, got);
        chk("R6 base 1 block", got, 8'h00);
        wr_reg(3'd4, 8'h05);
        run_pix(11'd100, 10'd50, 8'h5A, got);
        chk("R6 base 5 aliases block 1", got, 8'h00);
        wr_reg(3'd4, 8'h04);
        run_pix(11'd100, 10'd50, 8'h5A, got);
        chk("R6 base 4 aliases block 0", got, 8'hFF);
        wr_reg(3'd4, 8'h00);

        // R9: pattern write and fetch on the same edge
        @(negedge clk);
        pix_valid = 1'b1; beam_x = 11'd100; beam_y = 10'd50; pix_in = 8'h5A;
        pat_we = 1'b1; pat_addr = 10'd0; pat_wdata = 8'h00;
        @(negedge clk);
        pix_valid = 1'b0; pat_we = 1'b0;
        @(negedge clk);
        chk("R9 fetch sees old pattern byte", pix_out, 8'hFF);
        run_pix(11'd100, 10'd50, 8'h5A, got);
        chk("R9 next fetch sees new byte", got, 8'hA5);
        wr_pat(10'd0, 8'hCC);

        // R9: register write and pixel on the same edge
        @(negedge clk);
        pix_valid = 1'b1; beam_x = 11'd100; beam_y = 10'd50; pix_in = 8'h5A;
        reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 8'd200;
        @(negedge clk);
        pix_valid = 1'b0; reg_we = 1'b0;
        @(negedge clk);
        chk("R9 pixel uses old position", pix_out, 8'hFF);
        run_pix(11'd100, 10'd50, 8'h5A, got);
        chk("R9 old spot now outside", got, 8'h5A);
        run_pix(11'd200, 10'd50, 8'h5A, got);
        chk("R9 new position active", got, 8'hFF);

        // R2: disable, pixel inside window passes
        wr_reg(3'd5, 8'h00);
        run_pix(11'd200, 10'd50, 8'h5A, got);
        chk("R2 disabled pass-through", got, 8'h5A);
        run_pix(11'd203, 10'd50, 8'hC7, got);
        chk("R2 disabled pass-through black spot", got, 8'hC7);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule